// File: doc/BRIEF.md
# Palette Address Pointer with Byte-Pair Access

This block keeps the 11-bit address pointer behind a small microprocessor port. The port reaches a color palette and a bank of control registers. It has a chip-select, separate read and write strobes, a 2-bit register select and a 10-bit data bus. The pointer is narrower on the bus than in storage, so software moves it in two steps: the low byte first, then the high byte. A byte-order flag tracks which half comes next. The flag drops back to the low half whenever the access direction changes or a different register is touched between the two halves.

For palette traffic, software loads only a start address. The block then counts red, green and blue accesses and moves the pointer forward by one after each complete triple. It outputs the current pointer, the current color phase and the data returned by the last read. The palette storage, the control register file and the analog side are not part of this block.

An access is taken on the rising edge of a strobe while chip-select is high. A strobe that is held high is one access. Control pins are plain, level-sensitive signals. There is no streaming data path, so there is no back-pressure: every qualified strobe edge is accepted in the cycle it is seen.

Top module: `pal_ptr_ctrl`

## Requirements
- R1: After reset, `ptr` is 0, `phase` is 0 (red), `rdata` is 0, and the next pointer access reaches the low byte.
- R2: Register select value 0 addresses the pointer. A first write sets `ptr[7:0]` from `wdata[7:0]`. An immediately following write sets `ptr[10:8]` from `wdata[2:0]`, and `wdata[9:3]` are ignored. A third consecutive write reaches the low byte again.
- R3: With select 0, a first read returns `{2'b0, ptr[7:0]}` on `rdata` and an immediately following read returns `{7'b0, ptr[10:8]}`. `rdata` is registered and changes in the cycle after the strobe edge.
- R4: If the access direction changes between two pointer accesses (read after write, or write after read), the second access reaches the low byte.
- R5: An access with a select other than 0, placed between two pointer accesses, makes the next pointer access reach the low byte.
- R6: Select value 1 addresses the palette. Each palette read or write moves `phase` through 0 (red), 1 (green) and 2 (blue). The access taken in phase 2 returns `phase` to 0 and adds one to `ptr`, wrapping from 2047 to 0. `phase` never exceeds 2.
- R7: Any pointer write returns `phase` to 0.
- R8: One access is taken per rising edge of `wr_stb` or `rd_stb` while `cs` is high. A strobe held high for several cycles counts once. A strobe edge while `cs` is low changes nothing.
- R9: If both strobes rise in the same cycle, the access is taken as a write only: no read data is captured, and the byte-order flag follows write rules.
- R10: A read with a select of 2 or 3 returns 0 on `rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs | input | 1 | Chip-select, active high, qualifies both strobes |
| rd_stb | input | 1 | Read strobe, an access on its rising edge |
| wr_stb | input | 1 | Write strobe, an access on its rising edge |
| rsel | input | 2 | Register select: 0 pointer, 1 palette, 2 and 3 control registers |
| wdata | input | 10 | Write data bus |
| rdata | output | 10 | Data of the last read, registered |
| ptr | output | 11 | Current pointer value |
| phase | output | 2 | Color phase: 0 red, 1 green, 2 blue |

## Verification
Two functions can fall in the same cycle: a read strobe edge and a write strobe edge. The bench raises both strobes on one falling clock edge, right after a pointer read has left the byte-order flag expecting a second read. The result is judged from the pointer value and from `rdata`. `rdata` must keep its old value, the write must land in the low byte because the direction changed, and a following write must land in the high byte. A second collision is between a held strobe and the palette triple counter. The bench holds the write strobe for several cycles in the blue phase and expects exactly one pointer step.

// File: rtl/pal_ptr_pkg.sv
package pal_ptr_pkg;
  typedef enum logic [1:0] {
    RS_PTR  = 2'd0,
    RS_PAL  = 2'd1,
    RS_CTLA = 2'd2,
    RS_CTLB = 2'd3
  } regsel_e;

  localparam int NCOL = 3;
  localparam int PH_W = $clog2(NCOL);
endpackage

// File: rtl/pal_strobe_edge.sv
module pal_strobe_edge #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise
);
  logic [N-1:0] prev_q;

  for (genvar i = 0; i < N; i++) begin : g_edge
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q[i] <= 1'b0;
      else        prev_q[i] <= lvl[i];
    end
    assign rise[i] = lvl[i] & ~prev_q[i];
  end
endmodule

// File: rtl/pal_byte_seq.sv
module pal_byte_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic ev_wr,
  input  logic ev_rd,
  input  logic is_ptr,
  output logic hi_sel
);
  logic hi_next_q;
  logic last_wr_q;

  // the high half is reached only as the second access of the same direction
  assign hi_sel = hi_next_q & (last_wr_q == ev_wr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_next_q <= 1'b0;
      last_wr_q <= 1'b0;
    end else if (ev_wr || ev_rd) begin
      if (is_ptr) begin
        hi_next_q <= ~hi_sel;
        last_wr_q <= ev_wr;
      end else begin
        hi_next_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pal_rgb_step.sv
module pal_rgb_step #(
  parameter int NCOL = 3,
  localparam int PH_W = $clog2(NCOL)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            adv,
  input  logic            clr,
  output logic [PH_W-1:0] phase,
  output logic            wrap
);
  localparam logic [PH_W-1:0] LAST = PH_W'(NCOL - 1);
  logic [PH_W-1:0] ph_q;

  assign wrap  = adv && (ph_q == LAST);
  assign phase = ph_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ph_q <= '0;
    else if (clr)   ph_q <= '0;
    else if (wrap)  ph_q <= '0;
    else if (adv)   ph_q <= ph_q + PH_W'(1);
  end
endmodule

// File: rtl/pal_ptr_ctrl.sv
module pal_ptr_ctrl
  import pal_ptr_pkg::*;
#(
  parameter int PTR_W  = 11,
  parameter int DATA_W = 10,
  parameter int LO_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              rd_stb,
  input  logic              wr_stb,
  input  logic [1:0]        rsel,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [PTR_W-1:0]  ptr,
  output logic [1:0]        phase
);
  localparam int HI_W = PTR_W - LO_W;

  logic [1:0]        rise;
  logic              ev_wr, ev_rd, is_ptr, is_pal, hi_sel, step;
  logic [PH_W-1:0]   ph;
  logic [PTR_W-1:0]  ptr_q;
  logic [DATA_W-1:0] rdata_q;

  pal_strobe_edge #(.N(2)) u_edge (
    .clk(clk), .rst_n(rst_n),
    .lvl({cs & wr_stb, cs & rd_stb}),
    .rise(rise)
  );

  // write wins when both strobes rise together
  assign ev_wr  = rise[1];
  assign ev_rd  = rise[0] & ~rise[1];
  assign is_ptr = (rsel == RS_PTR);
  assign is_pal = (rsel == RS_PAL);

  pal_byte_seq u_seq (
    .clk(clk), .rst_n(rst_n),
    .ev_wr(ev_wr), .ev_rd(ev_rd), .is_ptr(is_ptr),
    .hi_sel(hi_sel)
  );

  pal_rgb_step #(.NCOL(NCOL)) u_rgb (
    .clk(clk), .rst_n(rst_n),
    .adv((ev_wr | ev_rd) & is_pal),
    .clr(ev_wr & is_ptr),
    .phase(ph),
    .wrap(step)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (ev_wr && is_ptr) begin
      if (hi_sel) ptr_q[PTR_W-1:LO_W] <= wdata[HI_W-1:0];
      else        ptr_q[LO_W-1:0]     <= wdata[LO_W-1:0];
    end else if (step) begin
      ptr_q <= ptr_q + PTR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (ev_rd) begin
      if (!is_ptr)     rdata_q <= '0;
      else if (hi_sel) rdata_q <= DATA_W'(ptr_q[PTR_W-1:LO_W]);
      else             rdata_q <= DATA_W'(ptr_q[LO_W-1:0]);
    end
  end

  assign ptr   = ptr_q;
  assign rdata = rdata_q;
  assign phase = 2'(ph);
endmodule

// File: rtl/pal_ptr_chk.sv
module pal_ptr_chk #(
  parameter int PTR_W  = 11,
  parameter int DATA_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs,
  input logic              rd_stb,
  input logic              wr_stb,
  input logic [1:0]        rsel,
  input logic [DATA_W-1:0] rdata,
  input logic [PTR_W-1:0]  ptr,
  input logic [1:0]        phase
);
  logic wp, rp;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= 1'b0;
      rp <= 1'b0;
    end else begin
      wp <= cs & wr_stb;
      rp <= cs & rd_stb;
    end
  end
  logic e_wr, e_rd, e_any;
  assign e_wr  = cs & wr_stb & ~wp;
  assign e_rd  = cs & rd_stb & ~rp & ~e_wr;
  assign e_any = e_wr | e_rd;

  AST_PHASE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    phase <= 2'd2); // R6
  AST_TRIPLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    e_any && rsel == 2'd1 && phase == 2'd2 |=> ptr == PTR_W'($past(ptr) + 1'b1) && phase == 2'd0); // R6
  AST_PTR_WR_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    e_wr && rsel == 2'd0 |=> phase == 2'd0); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !e_any |=> $stable(ptr) && $stable(phase) && $stable(rdata)); // R8
  AST_DUAL_NO_RD: assert property (@(posedge clk) disable iff (!rst_n)
    e_wr |=> $stable(rdata)); // R9
  AST_OTHER_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    e_rd && rsel[1] |=> rdata == '0); // R10
endmodule

bind pal_ptr_ctrl pal_ptr_chk #(.PTR_W(PTR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .rd_stb(rd_stb), .wr_stb(wr_stb),
  .rsel(rsel), .rdata(rdata), .ptr(ptr), .phase(phase)
);

// File: tb/sim_pal_ptr_ctrl.sv
module sim_pal_ptr_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cs = 0, rd_stb = 0, wr_stb = 0;
  logic [1:0] rsel = 0;
  logic [9:0] wdata = 0;
  logic [9:0] rdata;
  logic [10:0] ptr;
  logic [1:0] phase;

  always #4 clk = ~clk;

  pal_ptr_ctrl u0 (.clk(clk), .rst_n(rst_n), .cs(cs), .rd_stb(rd_stb), .wr_stb(wr_stb),
                   .rsel(rsel), .wdata(wdata), .rdata(rdata), .ptr(ptr), .phase(phase));

  typedef struct packed { logic [10:0] p; logic [1:0] ph; logic [9:0] rd; } exp_t;
  exp_t  exp_q[$];
  string tag_q[$];
  int checks = 0, fails = 0;
  bit done = 0;

  // reference model built from the requirements
  logic [10:0] mptr = 0;
  logic [1:0]  mph = 0;
  logic [9:0]  mrd = 0;
  bit mhi = 0, mlw = 0;

  task automatic model_ev(input bit w, input bit r, input logic [1:0] rs, input logic [9:0] wd);
    bit hi;
    if (!w && !r) return;
    if (w) r = 0;
    hi = mhi && (mlw == w);
    if (rs == 2'd0) begin
      if (w) begin
        if (hi) mptr[10:8] = wd[2:0]; else mptr[7:0] = wd[7:0];
        mph = 0;
      end else begin
        mrd = hi ? {7'b0, mptr[10:8]} : {2'b0, mptr[7:0]};
      end
      mhi = !hi;
      mlw = w;
    end else begin
      mhi = 0;
      if (r) mrd = 0;
      if (rs == 2'd1) begin
        if (mph == 2'd2) begin mph = 0; mptr = mptr + 11'd1; end
        else mph = mph + 2'd1;
      end
    end
  endtask

  task automatic push(input string tag);
    exp_q.push_back('{p: mptr, ph: mph, rd: mrd});
    tag_q.push_back(tag);
  endtask

  task automatic acc(input bit w, input bit r, input bit c, input logic [1:0] rs,
                     input logic [9:0] wd, input int hold, input string tag);
    @(negedge clk);
    cs = c; wr_stb = w; rd_stb = r; rsel = rs; wdata = wd;
    repeat (hold) @(posedge clk);
    @(negedge clk);
    wr_stb = 0; rd_stb = 0; cs = 0;
    @(posedge clk);
    #1;
    if (c) model_ev(w, r, rs, wd);
    push(tag);
  endtask

  // monitor: pops expectations and compares at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      while (exp_q.size() > 0) begin
        exp_t e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (ptr !== e.p || phase !== e.ph || rdata !== e.rd) begin
          fails++;
          $display("FAIL %s: actual ptr=%h phase=%0d rdata=%h expected ptr=%h phase=%0d rdata=%h",
                   t, ptr, phase, rdata, e.p, e.ph, e.rd);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog (run hung): actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 push("R1 reset state");
    @(negedge clk) rst_n = 1;
    // R2 write pair, upper data bits ignored, third write back to low
    acc(1, 0, 1, 2'd0, 10'h35A, 1, "R2 low byte write");
    acc(1, 0, 1, 2'd0, 10'h3FB, 1, "R2 high byte write");
    acc(1, 0, 1, 2'd0, 10'h011, 1, "R2 third write low");
    // R3 read pair (ptr now 0x311)
    acc(0, 1, 1, 2'd0, 10'h0, 1, "R3 read low");
    acc(0, 1, 1, 2'd0, 10'h0, 1, "R3 read high");
    // R4 direction change
    acc(1, 0, 1, 2'd0, 10'h022, 1, "R4 write low");
    acc(0, 1, 1, 2'd0, 10'h0, 1, "R4 read after write gets low");
    acc(1, 0, 1, 2'd0, 10'h044, 1, "R4 write after read gets low");
    acc(1, 0, 1, 2'd0, 10'h005, 1, "R4 pair completes high");
    // R5 intervening register, R10 control read returns zero
    acc(1, 0, 1, 2'd0, 10'h010, 1, "R5 write low");
    acc(0, 1, 1, 2'd2, 10'h0, 1, "R10 control read zero");
    acc(1, 0, 1, 2'd0, 10'h020, 1, "R5 low again after other reg");
    acc(1, 0, 1, 2'd3, 10'h0, 1, "R5 control write");
    acc(1, 0, 1, 2'd0, 10'h030, 1, "R5 low again after other write");
    // R6 palette triples
    acc(1, 0, 1, 2'd1, 10'h1, 1, "R6 red write");
    acc(1, 0, 1, 2'd1, 10'h2, 1, "R6 green write");
    acc(1, 0, 1, 2'd1, 10'h3, 1, "R6 blue write steps ptr");
    acc(0, 1, 1, 2'd1, 10'h0, 1, "R6 red read");
    acc(1, 0, 1, 2'd1, 10'h0, 1, "R6 green mixed");
    acc(0, 1, 1, 2'd1, 10'h0, 1, "R6 blue read steps ptr");
    // R7 pointer write clears phase
    acc(1, 0, 1, 2'd1, 10'h0, 1, "R7 red");
    acc(1, 0, 1, 2'd1, 10'h0, 1, "R7 green");
    acc(1, 0, 1, 2'd0, 10'h0FF, 1, "R7 pointer write clears phase");
    acc(1, 0, 1, 2'd0, 10'h007, 1, "R6 set 2047");
    for (int i = 0; i < 3; i++) acc(1, 0, 1, 2'd1, 10'h0, 1, "R6 wrap to zero");
    // R8 held strobe and missing chip-select
    acc(1, 0, 1, 2'd1, 10'h0, 1, "R8 red");
    acc(1, 0, 1, 2'd1, 10'h0, 1, "R8 green");
    acc(1, 0, 1, 2'd1, 10'h0, 5, "R8 held blue strobe steps once");
    acc(1, 0, 0, 2'd1, 10'h0, 1, "R8 palette write without cs");
    acc(1, 0, 0, 2'd0, 10'h0AA, 1, "R8 pointer write without cs");
    acc(0, 1, 0, 2'd0, 10'h0, 1, "R8 read without cs");
    // R9 both strobes after a pointer read
    acc(1, 0, 1, 2'd0, 10'h0C3, 1, "R9 setup write low");
    acc(1, 0, 1, 2'd0, 10'h002, 1, "R9 setup write high");
    acc(0, 1, 1, 2'd0, 10'h0, 1, "R9 read low");
    acc(1, 1, 1, 2'd0, 10'h05D, 1, "R9 dual strobe is write to low");
    acc(1, 0, 1, 2'd0, 10'h006, 1, "R9 next write high");
    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule